// File: doc/BRIEF.md
# Parallel Pipelined 16-Point FFT

The block computes a forward complex discrete Fourier transform of length 16 in a single spatially unrolled datapath. A whole frame of 16 complex samples (8-bit signed real and imaginary parts) is taken on one clock edge. After four clock cycles the 16 complex spectrum bins come out together, each part as a 16-bit two's complement number in 8.8 fixed point. A new frame may enter on every clock.

The datapath is a radix-2 decimation-in-time flow graph. It has four butterfly stages of eight butterflies each, and a register bank sits after every stage. Each butterfly rotates its lower operand by a constant twiddle factor using four real multiplications. It truncates the product back to 8.8 and then forms the sum and the difference. A valid flag and an order-select bit travel through the pipeline next to their frame. The select bit chooses whether the bins leave in natural order or in bit-reversed order.

Top module: `fft16_par`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` forces `out_valid_o` to 0 at once. `out_valid_o` stays 0 until a frame marked valid has had time to pass through the pipeline.
- R2: Input sample k sits at bits [8k+7:8k] of `in_re_i` and `in_im_i` as a signed 8-bit integer. On entry it becomes x·256, which is the integer x in 8.8 format.
- R3: Output bin j sits at bits [16j+15:16j] of `out_re_o` and `out_im_o` as a signed 16-bit 8.8 value. All additions wrap modulo 2^16 with no saturation.
- R4: Each butterfly with operands a, b and twiddle W produces a+t on its upper output and a−t on its lower output. Here t = b·W: the two real products of each part are summed at full width and then arithmetically shifted right by 14, which truncates toward minus infinity.
- R5: The twiddle W^e for e = 0..7 has real part round(cos(2πe/16)·16384) and imaginary part −round(sin(2πe/16)·16384). Rounding is to the nearest integer, with halves away from zero.
- R6: The flow graph is fixed. Position p of the first stage holds input sample bitrev4(p). Stage s (s = 0..3) pairs position p with position p+2^s wherever bit s of p is 0, and uses twiddle exponent (p mod 2^s)·2^(3−s). Position j after the last stage is bin X[j].
- R7: `out_valid_o` equals `in_valid_i` delayed by exactly 4 clock cycles. Frames entered on consecutive cycles come out on consecutive cycles.
- R8: With `bitrev_sel_i` = 0 the output slot j carries X[j]. With `bitrev_sel_i` = 1 it carries X[bitrev4(j)]. The select value is captured together with its frame, so each frame uses the value it entered with.
- R9: An input that is zero everywhere except sample 0 = a + jb gives every bin exactly a·256 + j·b·256.
- R10: A constant input c + jd on all 16 samples gives bin 0 = (16·c·256) + j(16·d·256), taken modulo 2^16. Every other bin is exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The input frame is valid |
| bitrev_sel_i | input | 1 | Output order for this frame: 0 natural, 1 bit-reversed |
| in_re_i | input | 128 | Real parts of 16 input samples, 8 bits each |
| in_im_i | input | 128 | Imaginary parts of 16 input samples, 8 bits each |
| out_valid_o | output | 1 | The output frame is valid |
| out_re_o | output | 256 | Real parts of 16 bins, 16-bit 8.8 each |
| out_im_o | output | 256 | Imaginary parts of 16 bins, 16-bit 8.8 each |

## Verification
The bench builds the block with its default values: length 16, 8-bit inputs, 16-bit 8.8 data and 2.14 twiddles. At this size an impulse can be placed in every one of the 16 input slots, and the constant-input test can cover every real amplitude from −8 to 7, including the cases where bin 0 wraps. Every output bin is compared bit for bit against an arithmetic model of the flow graph, both for small pseudo-random frames and for full-range ones. Frames run back to back with gaps in between and with the order select toggling frame by frame, so valid tracking and per-frame reordering are checked under pipelined traffic.

// File: rtl/fft_pkg.sv
package fft_pkg;

  localparam real TWO_PI = 6.283185307179586;

  function automatic int bit_rev(int idx, int bits);
    int r;
    r = 0;
    for (int b = 0; b < bits; b++) begin
      if (((idx >> b) & 1) == 1) r = r | (1 << (bits - 1 - b));
    end
    return r;
  endfunction

  function automatic int round_r(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  // W^e = cos(2*pi*e/n) - j*sin(2*pi*e/n), scaled by 2^frac
  function automatic int tw_re(int e, int n, int frac);
    return round_r($cos(TWO_PI * real'(e) / real'(n)) * real'(1 << frac));
  endfunction

  function automatic int tw_im(int e, int n, int frac);
    return -round_r($sin(TWO_PI * real'(e) / real'(n)) * real'(1 << frac));
  endfunction

endpackage

// File: rtl/fft_bfly.sv
module fft_bfly #(
  parameter int D_W     = 16,
  parameter int TW_W    = 16,
  parameter int TW_FRAC = 14,
  parameter int W_RE    = 16384,
  parameter int W_IM    = 0
) (
  input  logic signed [D_W-1:0] a_re_i,
  input  logic signed [D_W-1:0] a_im_i,
  input  logic signed [D_W-1:0] b_re_i,
  input  logic signed [D_W-1:0] b_im_i,
  output logic signed [D_W-1:0] top_re_o,
  output logic signed [D_W-1:0] top_im_o,
  output logic signed [D_W-1:0] bot_re_o,
  output logic signed [D_W-1:0] bot_im_o
);
  localparam int PW = D_W + TW_W + 1;
  localparam logic signed [PW-1:0] WR_X = PW'(W_RE);
  localparam logic signed [PW-1:0] WI_X = PW'(W_IM);

  logic signed [PW-1:0] br_x, bi_x, prod_re, prod_im;
  logic signed [D_W-1:0] t_re, t_im;

  assign br_x    = PW'(b_re_i);
  assign bi_x    = PW'(b_im_i);
  assign prod_re = br_x * WR_X - bi_x * WI_X;
  assign prod_im = br_x * WI_X + bi_x * WR_X;
  assign t_re    = D_W'(prod_re >>> TW_FRAC);
  assign t_im    = D_W'(prod_im >>> TW_FRAC);

  assign top_re_o = a_re_i + t_re;
  assign top_im_o = a_im_i + t_im;
  assign bot_re_o = a_re_i - t_re;
  assign bot_im_o = a_im_i - t_im;

  always_comb begin
    AST_BFLY_RE_SUM: assert (D_W'(top_re_o + bot_re_o) == D_W'(a_re_i + a_re_i)); // R4
    AST_BFLY_IM_SUM: assert (D_W'(top_im_o + bot_im_o) == D_W'(a_im_i + a_im_i)); // R4
  end

endmodule

// File: rtl/fft_stage.sv
module fft_stage #(
  parameter int N       = 16,
  parameter int S       = 0,
  parameter int D_W     = 16,
  parameter int TW_W    = 16,
  parameter int TW_FRAC = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sel_i,
  input  logic [N*D_W-1:0] re_i,
  input  logic [N*D_W-1:0] im_i,
  output logic             valid_o,
  output logic             sel_o,
  output logic [N*D_W-1:0] re_o,
  output logic [N*D_W-1:0] im_o
);
  localparam int H = 1 << S;

  logic [N*D_W-1:0] re_d, im_d;

  for (genvar b = 0; b < N / 2; b++) begin : g_bfly
    localparam int P = ((b / H) * 2 * H) + (b % H);
    localparam int Q = P + H;
    localparam int E = (P % H) * (N / (2 * H));
    fft_bfly #(
      .D_W    (D_W),
      .TW_W   (TW_W),
      .TW_FRAC(TW_FRAC),
      .W_RE   (fft_pkg::tw_re(E, N, TW_FRAC)),
      .W_IM   (fft_pkg::tw_im(E, N, TW_FRAC))
    ) u_bfly (
      .a_re_i  (re_i[P*D_W +: D_W]),
      .a_im_i  (im_i[P*D_W +: D_W]),
      .b_re_i  (re_i[Q*D_W +: D_W]),
      .b_im_i  (im_i[Q*D_W +: D_W]),
      .top_re_o(re_d[P*D_W +: D_W]),
      .top_im_o(im_d[P*D_W +: D_W]),
      .bot_re_o(re_d[Q*D_W +: D_W]),
      .bot_im_o(im_d[Q*D_W +: D_W])
    );
  end

  always_ff @(posedge clk_i) begin
    re_o <= re_d;
    im_o <= im_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sel_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sel_o   <= sel_i;
    end
  end

  AST_VALID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i))); // R7
  AST_SEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && valid_o) |-> (sel_o == $past(sel_i))); // R8

endmodule

// File: rtl/fft16_par.sv
module fft16_par #(
  parameter int N       = 16,
  parameter int IN_W    = 8,
  parameter int D_W     = 16,
  parameter int FRAC    = 8,
  parameter int TW_W    = 16,
  parameter int TW_FRAC = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              bitrev_sel_i,
  input  logic [N*IN_W-1:0] in_re_i,
  input  logic [N*IN_W-1:0] in_im_i,
  output logic              out_valid_o,
  output logic [N*D_W-1:0]  out_re_o,
  output logic [N*D_W-1:0]  out_im_o
);
  localparam int STAGES = $clog2(N);
  localparam int CW     = $clog2(STAGES + 1);

  logic [N*D_W-1:0] st_re  [STAGES+1];
  logic [N*D_W-1:0] st_im  [STAGES+1];
  logic             st_v   [STAGES+1];
  logic             st_sel [STAGES+1];

  assign st_v[0]   = in_valid_i;
  assign st_sel[0] = bitrev_sel_i;

  // bit-reversed load, 8.8 scaling
  for (genvar p = 0; p < N; p++) begin : g_in
    localparam int SRC = fft_pkg::bit_rev(p, STAGES);
    logic signed [D_W-1:0] ext_re, ext_im;
    assign ext_re = D_W'($signed(in_re_i[SRC*IN_W +: IN_W]));
    assign ext_im = D_W'($signed(in_im_i[SRC*IN_W +: IN_W]));
    assign st_re[0][p*D_W +: D_W] = ext_re <<< FRAC;
    assign st_im[0][p*D_W +: D_W] = ext_im <<< FRAC;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    fft_stage #(
      .N      (N),
      .S      (s),
      .D_W    (D_W),
      .TW_W   (TW_W),
      .TW_FRAC(TW_FRAC)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(st_v[s]),
      .sel_i  (st_sel[s]),
      .re_i   (st_re[s]),
      .im_i   (st_im[s]),
      .valid_o(st_v[s+1]),
      .sel_o  (st_sel[s+1]),
      .re_o   (st_re[s+1]),
      .im_o   (st_im[s+1])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    localparam int BR = fft_pkg::bit_rev(j, STAGES);
    assign out_re_o[j*D_W +: D_W] = st_sel[STAGES] ? st_re[STAGES][BR*D_W +: D_W]
                                                   : st_re[STAGES][j*D_W +: D_W];
    assign out_im_o[j*D_W +: D_W] = st_sel[STAGES] ? st_im[STAGES][BR*D_W +: D_W]
                                                   : st_im[STAGES][j*D_W +: D_W];
  end

  assign out_valid_o = st_v[STAGES];

  // cycles since reset, saturating; qualifies the end-to-end check
  logic [CW-1:0] live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    live_q <= '0;
    else if (live_q != CW'(STAGES)) live_q <= live_q + 1'b1;
  end

  AST_OUT_VALID_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == CW'(STAGES)) |-> (out_valid_o == $past(in_valid_i, STAGES))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q != CW'(STAGES)) |-> !out_valid_o); // R1

endmodule

// File: tb/tb_fft16_par.sv
module tb_fft16_par;
  localparam int N  = 16;
  localparam int NF = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, bitrev_sel_i = 1'b0;
  logic [N*8-1:0]  in_re_i = '0, in_im_i = '0;
  logic            out_valid_o;
  logic [N*16-1:0] out_re_o, out_im_o;

  fft16_par dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .bitrev_sel_i(bitrev_sel_i),
    .in_re_i(in_re_i), .in_im_i(in_im_i), .out_valid_o(out_valid_o),
    .out_re_o(out_re_o), .out_im_o(out_im_o)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int xr[N], xi[N];
  bit fv, fsel;
  int exp_re[NF][N], exp_im[NF][N];
  bit exp_v[NF], exp_sel[NF];
  int kind[NF], par_a[NF], par_b[NF];
  int unsigned lfsr = 32'h1234_5678;

  function automatic int w16(longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int brev(int i);
    int r = 0;
    for (int b = 0; b < 4; b++) if (((i >> b) & 1) == 1) r |= 1 << (3 - b);
    return r;
  endfunction

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic int next_rand();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return int'(lfsr[15:0]);
  endfunction

  task automatic check(string tag, int f, int j, int act, int expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s frame=%0d bin=%0d actual=%0d expected=%0d", tag, f, j, act, expv);
    end
  endtask

  // R2, R4, R5, R6, R8: arithmetic model of the flow graph
  task automatic run_model(int f);
    int ar[N], ai[N];
    for (int p = 0; p < N; p++) begin
      ar[p] = w16(xr[brev(p)] * 256);
      ai[p] = w16(xi[brev(p)] * 256);
    end
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < N; p++) begin
        if (((p >> s) & 1) == 0) begin
          int q, e, wr, wi, tr, ti, a_r, a_i;
          longint pr, pi;
          q  = p + (1 << s);
          e  = (p % (1 << s)) * (8 >> s);
          wr = rnd($cos(6.283185307179586 * e / 16.0) * 16384.0);
          wi = -rnd($sin(6.283185307179586 * e / 16.0) * 16384.0);
          pr = longint'(ar[q]) * wr - longint'(ai[q]) * wi;
          pi = longint'(ar[q]) * wi + longint'(ai[q]) * wr;
          tr = w16(pr >>> 14);
          ti = w16(pi >>> 14);
          a_r = ar[p]; a_i = ai[p];
          ar[p] = w16(a_r + tr); ai[p] = w16(a_i + ti);
          ar[q] = w16(a_r - tr); ai[q] = w16(a_i - ti);
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      exp_re[f][j] = ar[fsel ? brev(j) : j];
      exp_im[f][j] = ai[fsel ? brev(j) : j];
    end
  endtask

  task automatic make_frame(int f);
    fv = 1'b1;
    fsel = (f % 3 == 1);
    kind[f] = 0;
    for (int k = 0; k < N; k++) begin xr[k] = 0; xi[k] = 0; end
    if (f < 16) begin
      xr[f] = (f % 2 == 1) ? -100 : 90;
      xi[f] = f - 8;
    end else if (f < 32) begin
      kind[f] = 1; par_a[f] = f - 24; par_b[f] = 2 * (f - 24);
      for (int k = 0; k < N; k++) begin xr[k] = par_a[f]; xi[k] = par_b[f]; end
    end else if (f < 48) begin
      kind[f] = 2; par_a[f] = (f - 40) * 16; par_b[f] = -(f - 40) * 8;
      xr[0] = par_a[f]; xi[0] = par_b[f];
    end else begin
      fv = !((f < 64) && (f % 2 == 0));
      for (int k = 0; k < N; k++) begin
        if (f < 130) begin
          xr[k] = (next_rand() % 32) - 16; xi[k] = (next_rand() % 32) - 16;
        end else begin
          xr[k] = w16(next_rand()) >>> 8; xi[k] = w16(next_rand()) >>> 8;
        end
      end
      if (f == 150) for (int k = 0; k < N; k++) begin xr[k] = -128; xi[k] = 127; end
    end
    exp_v[f] = fv;
    exp_sel[f] = fsel;
    run_model(f);
  endtask

  task automatic check_frame(int f);
    checks++;
    if (out_valid_o !== exp_v[f]) begin
      failures++;
      $display("FAIL R7 frame=%0d out_valid actual=%0d expected=%0d", f, out_valid_o, exp_v[f]);
    end
    if (!exp_v[f]) return;
    for (int j = 0; j < N; j++) begin
      int ar, ai, er, ei;
      ar = int'($signed(out_re_o[j*16 +: 16]));
      ai = int'($signed(out_im_o[j*16 +: 16]));
      check(exp_sel[f] ? "R8 bitrev" : "R6/R3 natural", f, j, ar, exp_re[f][j]);
      check(exp_sel[f] ? "R8 bitrev" : "R6/R3 natural", f, j, ai, exp_im[f][j]);
      if (kind[f] == 1) begin
        er = (j == 0) ? w16(16 * par_a[f] * 256) : 0;
        ei = (j == 0) ? w16(16 * par_b[f] * 256) : 0;
        check("R10 dc", f, j, ar, er);
        check("R10 dc", f, j, ai, ei);
      end else if (kind[f] == 2) begin
        check("R9 impulse", f, j, ar, par_a[f] * 256);
        check("R9 impulse", f, j, ai, par_b[f] * 256);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset out_valid actual=%0d expected=0", out_valid_o);
    end
    rst_ni = 1'b1;
    for (int f = 0; f < NF + 4; f++) begin
      @(negedge clk);
      if (f >= 4) check_frame(f - 4);
      else begin
        checks++;
        if (out_valid_o !== 1'b0) begin
          failures++;
          $display("FAIL R1 startup out_valid actual=%0d expected=0", out_valid_o);
        end
      end
      if (f < NF) begin
        make_frame(f);
        in_valid_i   = fv;
        bitrev_sel_i = fsel;
        for (int k = 0; k < N; k++) begin
          in_re_i[k*8 +: 8] = 8'(xr[k]);   // R2 slot layout
          in_im_i[k*8 +: 8] = 8'(xi[k]);
        end
      end else in_valid_i = 1'b0;
    end
    // R1: asynchronous reset mid-stream
    in_valid_i = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b1) begin
      failures++;
      $display("FAIL R7 stream out_valid actual=%0d expected=1", out_valid_o);
    end
    rst_ni = 1'b0;
    #1;
    checks++;
    if (out_valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 async out_valid actual=%0d expected=0", out_valid_o);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule